// File: doc/BRIEF.md
# Per-Channel Output Power Mode Controller

This block keeps one 2-bit output mode for each channel of a multi-channel converter. The mode tells an analog wrapper whether that channel's output buffer is driving, floating, or shut down with a pull-down. There are two pull-down strengths, one strong and one weak. A decoded power command carries a channel mask and a 2-bit mode. Every channel whose mask bit is set takes the new mode. Every other channel keeps its mode.

Three events put every channel back into the weak pull-down shutdown: the power-on reset, a software reset strobe, and an asynchronous hardware clear. A combinational flag reports when no channel is driving, so the supply can be gated.

Top module: `chan_pwr_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, every channel reads 2'b00 (weak pull-down shutdown), and `all_off` is 1.
- R2: A command (`cmd_vld`=1) with `cmd_mode`=2'b11 sets each channel whose mask bit is 1 to 2'b11 (active) at the next rising clock edge.
- R3: A command with `cmd_mode`=2'b01 sets each selected channel to 2'b01 (shut down, output high-impedance).
- R4: A command with `cmd_mode`=2'b10 sets each selected channel to 2'b10 (shut down, strong pull-down).
- R5: A command with `cmd_mode`=2'b00 sets each selected channel to 2'b00 (shut down, weak pull-down).
- R6: Mask bit i selects channel i, and channel i drives `chan_mode[2*i+1:2*i]`. A channel whose mask bit is 0 keeps its mode through a command.
- R7: `sw_rst` high at a rising edge returns every channel to 2'b00. It wins over a command in the same cycle.
- R8: Driving `clr_n` low forces every channel to 2'b00 at once, without waiting for a clock edge.
- R9: `all_off` is 1 exactly when no channel is in mode 2'b11.
- R10: With `cmd_vld` and `sw_rst` both low, no channel mode changes, whatever `cmd_mask` and `cmd_mode` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Asynchronous hardware clear, active low |
| cmd_vld | input | 1 | Power command strobe |
| cmd_mask | input | 8 | Channel select; bit i selects channel i |
| cmd_mode | input | 2 | Mode applied to the selected channels |
| sw_rst | input | 1 | Software reset strobe |
| chan_mode | output | 16 | Mode of channel i on bits [2i+1:2i] |
| all_off | output | 1 | High when no channel is active |

## Verification
A channel register holding the wrong mode shows up on its own `chan_mode` slice in the first cycle after the command that wrote it. If the wrong mode is, or wrongly replaces, an active state, `all_off` is wrong in that same cycle. Mask-routing faults only show when the bench compares channels that were not selected against their earlier modes, so each command is followed by a check of all eight slices. A clear that only acts synchronously shows no error at a clock edge. It is caught only by sampling between the fall of `clr_n` and the next edge.

// File: rtl/chan_pwr_ctl.sv
module chan_pwr_ctl #(
  parameter int NCH = 8,
  parameter int MW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cmd_vld,
  input  logic [NCH-1:0]    cmd_mask,
  input  logic [MW-1:0]     cmd_mode,
  input  logic              sw_rst,
  output logic [NCH*MW-1:0] chan_mode,
  output logic              all_off
);
  localparam logic [MW-1:0] ST_WEAK = '0;
  localparam logic [MW-1:0] ST_ON   = '1;

  logic arst_n;
  assign arst_n = rst_n & clr_n;

  logic [NCH-1:0] on_vec;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [MW-1:0] st;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                     st <= ST_WEAK;
      else if (sw_rst)                 st <= ST_WEAK;
      else if (cmd_vld && cmd_mask[i]) st <= cmd_mode;
    end
    assign chan_mode[i*MW +: MW] = st;
    assign on_vec[i] = (st == ST_ON);
  end

  assign all_off = ~|on_vec;
endmodule

// File: rtl/chan_pwr_ctl_chk.sv
module chan_pwr_ctl_chk #(
  parameter int NCH = 8,
  parameter int MW  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              cmd_vld,
  input logic [NCH-1:0]    cmd_mask,
  input logic [MW-1:0]     cmd_mode,
  input logic              sw_rst,
  input logic [NCH*MW-1:0] chan_mode,
  input logic              all_off
);
  // R8
  clear_forces_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> chan_mode == '0);

  // R7
  swrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    sw_rst |=> chan_mode == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (!cmd_vld && !sw_rst) |=> $stable(chan_mode));

  // R9
  powerup_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (cmd_vld && !sw_rst && cmd_mask != '0 && cmd_mode == '1) |=> !all_off);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R2 R3 R4 R5
    sel_takes_mode_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (cmd_vld && !sw_rst && cmd_mask[i]) |=> chan_mode[i*MW +: MW] == $past(cmd_mode));
    // R6
    unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (cmd_vld && !sw_rst && !cmd_mask[i]) |=> $stable(chan_mode[i*MW +: MW]));
  end
endmodule

bind chan_pwr_ctl chan_pwr_ctl_chk #(.NCH(NCH), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_vld(cmd_vld),
  .cmd_mask(cmd_mask), .cmd_mode(cmd_mode), .sw_rst(sw_rst),
  .chan_mode(chan_mode), .all_off(all_off)
);

// File: tb/chan_pwr_ctl_tb.sv
module chan_pwr_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        cmd_vld = 1'b0;
  logic [7:0]  cmd_mask = '0;
  logic [1:0]  cmd_mode = '0;
  logic        sw_rst = 1'b0;
  logic [15:0] chan_mode;
  logic        all_off;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] exp_m = '0;

  always #4 clk = ~clk;

  chan_pwr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_vld(cmd_vld),
    .cmd_mask(cmd_mask), .cmd_mode(cmd_mode), .sw_rst(sw_rst),
    .chan_mode(chan_mode), .all_off(all_off)
  );

  function automatic logic exp_off(input logic [15:0] m);
    for (int i = 0; i < 8; i++) if (m[2*i +: 2] == 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req);
    nchk++;
    if (chan_mode !== exp_m) begin
      nfail++;
      $display("FAIL %s chan_mode=%h expected %h", req, chan_mode, exp_m);
    end
    nchk++;
    if (all_off !== exp_off(exp_m)) begin
      nfail++;
      $display("FAIL R9 (%s) all_off=%b expected %b", req, all_off, exp_off(exp_m));
    end
  endtask

  task automatic do_cmd(input logic [7:0] m, input logic [1:0] md, input string req);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_mask = m; cmd_mode = md;
    @(negedge clk);
    cmd_vld = 1'b0;
    for (int i = 0; i < 8; i++) if (m[i]) exp_m[2*i +: 2] = md;
    check(req);
  endtask

  task automatic t_reset();
    #1 check("R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
  endtask

  task automatic t_modes();
    do_cmd(8'h05, 2'b11, "R2 power-up 0x05");
    do_cmd(8'h82, 2'b01, "R3 hi-z 0x82");
    do_cmd(8'h30, 2'b10, "R4 strong 0x30");
    do_cmd(8'hF0, 2'b11, "R2 power-up 0xF0");
    do_cmd(8'h01, 2'b00, "R5 weak 0x01");
    do_cmd(8'h00, 2'b10, "R6 empty mask");
    do_cmd(8'h80, 2'b10, "R6 top channel only");
    do_cmd(8'h24, 2'b00, "R5 weak 0x24");
  endtask

  task automatic t_idle();
    @(negedge clk);
    cmd_vld = 1'b0; cmd_mask = 8'hFF; cmd_mode = 2'b01;
    repeat (2) @(negedge clk);
    check("R10 no strobe");
  endtask

  task automatic t_swrst();
    do_cmd(8'hFF, 2'b11, "R2 all on");
    @(negedge clk);
    sw_rst = 1'b1; cmd_vld = 1'b1; cmd_mask = 8'hFF; cmd_mode = 2'b11;
    @(negedge clk);
    sw_rst = 1'b0; cmd_vld = 1'b0;
    exp_m = '0;
    check("R7 sw reset over command");
  endtask

  task automatic t_clear();
    do_cmd(8'h5A, 2'b11, "R2 power-up 0x5A");
    @(negedge clk);
    #1 clr_n = 1'b0;
    #1 exp_m = '0;
    check("R8 async clear before edge");
    @(negedge clk);
    clr_n = 1'b1;
    do_cmd(8'h40, 2'b01, "R3 after clear");
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_modes();
    t_idle();
    t_swrst();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule